// File: doc/BRIEF.md
# Memory Aliasing Self-Test Engine

This block tests a region of RAM through a simple synchronous memory port. When it is started, it first writes every word of the region. It then reads every word back and compares each one with the value it wrote. The write data is the word's index in the region taken modulo a prime number (251 by default). Because of this, the data sequence never repeats over a span whose length is a power of two.

A typical wiring fault makes one power-of-two RAM block answer at several addresses. In that case the later writes overwrite the earlier ones, so the aliased block cannot hold the right value for every address that maps onto it. The readback then reports a mismatch. The same test also finds stuck or swapped data bits.

The engine reports three things:
- the first address that failed,
- the value expected there,
- the value actually read there.

A configuration input chooses whether the engine stops at the first mismatch or finishes the whole read pass.

The controller is a five-state machine:
- `ST_IDLE`: waits after reset.
- `ST_WRITE`: one write per cycle.
- `ST_READ`: one read per cycle.
- `ST_DRAIN`: one cycle that waits for the last read data.
- `ST_DONE`: result held.

The transitions are:
- `ST_IDLE`→`ST_WRITE` on start.
- `ST_WRITE`→`ST_READ` after the last write.
- `ST_READ`→`ST_DRAIN` after the last read is issued.
- `ST_READ`→`ST_DONE` on a mismatch when stop-on-fail is set.
- `ST_DRAIN`→`ST_DONE` always.
- `ST_DONE`→`ST_WRITE` on a new start.

Top module: `mem_alias_tester`

## Requirements
- R1: After reset, `done_o` and `fail_o` are 0, `mem_req_o` is 0, and the engine stays idle until `start_i` is sampled high.
- R2: The write pass issues exactly REGION_LEN writes, one per cycle, with `mem_req_o`=1 and `mem_we_o`=1. Write number i (counting from 0) goes to address BASE_ADDR+i and carries the data i mod PAT_MOD.
- R3: The read pass starts only after the last write. It issues reads (`mem_req_o`=1, `mem_we_o`=0) to addresses BASE_ADDR+i in ascending order. Read data is taken one cycle after the read request.
- R4: On a memory that stores every word faithfully, the run ends with `done_o`=1 and `fail_o`=0 after REGION_LEN writes and REGION_LEN reads.
- R5: On a memory that ignores address bit 7, with the defaults (BASE_ADDR=0, REGION_LEN=256, PAT_MOD=251), the run ends with `fail_o`=1, failing address 0, expected value 0 and actual value 128.
- R6: On a memory whose data bit 3 always reads as 0, the run reports failing address 8, expected value 8 and actual value 0.
- R7: Only the first mismatch is recorded. Later mismatches leave the failing address and both data values unchanged, and `fail_o` stays 1 until the next start.
- R8: When `stop_on_fail_i`=1, the run reaches `ST_DONE` on the cycle after the first mismatch is seen, and issues fewer than REGION_LEN reads. When it is 0, all REGION_LEN reads are issued.
- R9: `done_o` holds at 1 with no memory requests until a new start is accepted. The next start clears `done_o` and `fail_o` before the new passes begin.
- R10: `start_i` has no effect while a run is in progress. The run in progress still issues exactly REGION_LEN writes in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a test run (taken only when idle or done) |
| stop_on_fail_i | input | 1 | 1 = end the run at the first mismatch |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid one cycle after the read request |
| done_o | output | 1 | Run finished, result valid |
| fail_o | output | 1 | At least one mismatch was seen |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_exp_o | output | DATA_W | Value expected at that address |
| fail_act_o | output | DATA_W | Value read at that address |

## Verification
The engine runs against three memory behaviours. A faithful memory shows that the engine raises no false failure. A memory that ignores address bit 7 shows that aliasing is caught at the first address and that the later overwrite is what gets read back. A memory with data bit 3 stuck low shows a plain data-path fault, found at a different first address. Each faulty memory is run once with stop-on-fail set and once without, which separates early termination from the full pass while the first-failure record stays the same. A start pulse in the middle of a run, and a restart after a failed run, check that start is ignored while busy and that a new start clears the old result.

// File: rtl/mat_pkg.sv
package mat_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_DRAIN,
        ST_DONE
    } mat_state_e;
endpackage

// File: rtl/mat_pattern_gen.sv
// Data pattern generator: a counter that wraps at PAT_MOD, so its period is never a power of two.
module mat_pattern_gen #(
    parameter int DATA_W  = 8,
    parameter int PAT_MOD = 251
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    output logic [DATA_W-1:0] value_o
);
    localparam logic [DATA_W-1:0] WRAP_AT = DATA_W'(PAT_MOD - 1);

    logic [DATA_W-1:0] value_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (clear_i) begin
            value_q <= '0;
        end else if (step_i) begin
            value_q <= (value_q == WRAP_AT) ? '0 : value_q + 1'b1;
        end
    end

    assign value_o = value_q;

    // R2: the pattern value always stays below the modulus
    assert_pattern_below_mod_R2: assert property (@(posedge clk) disable iff (!rst_n)
        value_q <= WRAP_AT);
endmodule

// File: rtl/mat_addr_seq.sv
// Index sequencer: counts through the region and flags the last word.
module mat_addr_seq #(
    parameter int REGION_LEN = 256,
    parameter int IDX_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REGION_LEN - 1);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clear_i) begin
            idx_q <= '0;
        end else if (step_i) begin
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (idx_q == LAST_IDX);

    // R2: the index never runs past the end of the region
    assert_idx_in_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_IDX);
endmodule

// File: rtl/mat_fail_capture.sv
// Compares read data with the expected value and keeps the first mismatch only.
module mat_fail_capture #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              check_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [DATA_W-1:0] act_i,
    output logic              mismatch_o,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [DATA_W-1:0] fail_exp_o,
    output logic [DATA_W-1:0] fail_act_o
);
    logic              fail_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] exp_q;
    logic [DATA_W-1:0] act_q;

    assign mismatch_o = check_i && (exp_i != act_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
            addr_q <= '0;
            exp_q  <= '0;
            act_q  <= '0;
        end else if (clear_i) begin
            fail_q <= 1'b0;
            addr_q <= '0;
            exp_q  <= '0;
            act_q  <= '0;
        end else if (mismatch_o && !fail_q) begin
            fail_q <= 1'b1;
            addr_q <= addr_i;
            exp_q  <= exp_i;
            act_q  <= act_i;
        end
    end

    assign fail_o      = fail_q;
    assign fail_addr_o = addr_q;
    assign fail_exp_o  = exp_q;
    assign fail_act_o  = act_q;

    // R7: once a failure is recorded, its record is kept until cleared
    assert_first_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !clear_i) |=> (fail_q && $stable(addr_q) && $stable(exp_q) && $stable(act_q)));
endmodule

// File: rtl/mem_alias_tester.sv
module mem_alias_tester
    import mat_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int BASE_ADDR  = 0,
    parameter int REGION_LEN = 256,
    parameter int PAT_MOD    = 251
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_on_fail_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              done_o,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [DATA_W-1:0] fail_exp_o,
    output logic [DATA_W-1:0] fail_act_o
);
    localparam int IDX_W = (REGION_LEN > 1) ? $clog2(REGION_LEN) : 1;
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

    mat_state_e state_q, state_d;

    logic              start_acc;
    logic              seq_clear, seq_step, seq_last;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] pat;
    logic              rd_issue;
    logic              rd_vld_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [DATA_W-1:0] rd_exp_q;
    logic              mismatch;
    logic              abort;

    // ---------------- sub-blocks ----------------
    mat_addr_seq #(.REGION_LEN(REGION_LEN), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .clear_i(seq_clear), .step_i(seq_step),
        .idx_o(idx), .last_o(seq_last)
    );

    mat_pattern_gen #(.DATA_W(DATA_W), .PAT_MOD(PAT_MOD)) u_pat (
        .clk(clk), .rst_n(rst_n), .clear_i(seq_clear), .step_i(seq_step),
        .value_o(pat)
    );

    mat_fail_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear_i(start_acc), .check_i(rd_vld_q),
        .addr_i(rd_addr_q), .exp_i(rd_exp_q), .act_i(mem_rdata_i),
        .mismatch_o(mismatch), .fail_o(fail_o), .fail_addr_o(fail_addr_o),
        .fail_exp_o(fail_exp_o), .fail_act_o(fail_act_o)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign start_acc = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    assign abort     = mismatch && stop_on_fail_i;

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_acc) state_d = ST_WRITE;
            ST_WRITE: if (seq_last)  state_d = ST_READ;
            ST_READ: begin
                if (abort)         state_d = ST_DONE;
                else if (seq_last) state_d = ST_DRAIN;
            end
            ST_DRAIN: state_d = ST_DONE;
            ST_DONE:  if (start_acc) state_d = ST_WRITE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs and sequencer control ----------------
    always_comb begin
        mem_req_o = 1'b0;
        mem_we_o  = 1'b0;
        seq_step  = 1'b0;
        seq_clear = start_acc;
        rd_issue  = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WRITE: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
                seq_step  = 1'b1;
                if (seq_last) seq_clear = 1'b1;
            end
            ST_READ: begin
                mem_req_o = 1'b1;
                seq_step  = 1'b1;
                rd_issue  = 1'b1;
            end
            ST_DRAIN: ;
            ST_DONE:  done_o = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr_o  = BASE + ADDR_W'(idx);
    assign mem_wdata_o = pat;

    // read pipeline: expected value and address travel with the one-cycle read latency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld_q  <= 1'b0;
            rd_addr_q <= '0;
            rd_exp_q  <= '0;
        end else begin
            rd_vld_q  <= rd_issue && !abort;
            rd_addr_q <= mem_addr_o;
            rd_exp_q  <= pat;
        end
    end

    // ---------------- assertions ----------------
    // R2: all accesses fall inside the region
    assert_addr_in_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> ((32'(mem_addr_o) - 32'(BASE_ADDR)) < 32'(REGION_LEN)));

    // R9: a finished run issues no memory traffic
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o);

    // R9: done holds until a start is accepted
    assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R7: fail is sticky until the next accepted start
    assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_acc) |=> fail_o);

    // R8: with stop-on-fail, a mismatch ends the run on the next cycle
    assert_stop_on_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && stop_on_fail_i) |=> done_o);
endmodule

// File: tb/mem_alias_tester_tb.sv
module mem_alias_tester_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int LEN    = 256;
    localparam int MODV   = 251;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic stop_on_fail = 1'b0;
    logic mem_req, mem_we, done, fail;
    logic [ADDR_W-1:0] mem_addr, fail_addr;
    logic [DATA_W-1:0] mem_wdata, fail_exp, fail_act;
    logic [DATA_W-1:0] mem_rdata = '0;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int mode = 0;            // 0 faithful, 1 address bit 7 ignored, 2 data bit 3 stuck low
    int run_wr = 0;
    int run_rd = 0;
    int seq_err = 0;

    logic [DATA_W-1:0] mem [LEN];

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_alias_tester #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(0),
                       .REGION_LEN(LEN), .PAT_MOD(MODV)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .stop_on_fail_i(stop_on_fail),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .done_o(done),
        .fail_o(fail), .fail_addr_o(fail_addr), .fail_exp_o(fail_exp),
        .fail_act_o(fail_act)
    );

    // memory model with selectable faults
    function automatic int eff_addr(input logic [ADDR_W-1:0] a);
        if (mode == 1) return int'({1'b0, a[6:0]});
        return int'(a);
    endfunction

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[eff_addr(mem_addr)] <= mem_wdata;
        if (mem_req && !mem_we) begin
            if (mode == 2) mem_rdata <= mem[eff_addr(mem_addr)] & 8'hF7;
            else           mem_rdata <= mem[eff_addr(mem_addr)];
        end
    end

    // port-level sequence monitor (R2, R3)
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (mem_we) begin
                if (int'(mem_addr) != run_wr || int'(mem_wdata) != (run_wr % MODV) || run_rd != 0)
                    seq_err++;
                run_wr++;
            end else begin
                if (int'(mem_addr) != run_rd || run_wr != LEN) seq_err++;
                run_rd++;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input int m, input bit stop, input bit poke_start);
        mode = m;
        stop_on_fail = stop;
        @(negedge clk);
        run_wr = 0; run_rd = 0; seq_err = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0 && fail == 1'b0, "R9 start clears done/fail", int'({done, fail}), 0);
        if (poke_start) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        check(done == 0 && fail == 0 && mem_req == 0, "R1 reset state",
              int'({done, fail, mem_req}), 0);
        repeat (5) @(negedge clk);
        check(mem_req == 0 && run_wr == 0, "R1 idle without start", run_wr, 0);
    endtask

    task automatic t_good;
        run(0, 1'b0, 1'b0);
        check(done && !fail, "R4 faithful memory passes", int'(fail), 0);
        check(run_wr == LEN && seq_err == 0, "R2 write pass order/data", run_wr + 1000*seq_err, LEN);
        check(run_rd == LEN && seq_err == 0, "R3 read pass order", run_rd, LEN);
        repeat (10) @(negedge clk);
        check(done && !mem_req && run_rd == LEN, "R9 done held quietly", run_rd, LEN);
    endtask

    task automatic t_alias(input bit stop);
        run(1, stop, 1'b0);
        check(done && fail, "R5 aliased memory flagged", int'(fail), 1);
        check(fail_addr == 0 && fail_exp == 0 && fail_act == 128, "R5 alias record",
              int'(fail_act) + 1000*int'(fail_addr), 128);
        if (stop) check(run_rd < LEN, "R8 stop-on-fail ends early", run_rd, 2);
        else      check(run_rd == LEN, "R8 full pass without stop", run_rd, LEN);
        if (!stop) check(fail_addr == 0, "R7 first failure kept", int'(fail_addr), 0);
    endtask

    task automatic t_stuck(input bit stop);
        run(2, stop, 1'b0);
        check(done && fail && fail_addr == 8 && fail_exp == 8 && fail_act == 0,
              "R6 stuck bit record", int'(fail_addr), 8);
        if (!stop) check(fail_addr == 8 && fail_act == 0, "R7 later mismatches ignored",
                         int'(fail_addr), 8);
    endtask

    task automatic t_busy_start;
        run(0, 1'b0, 1'b1);
        check(run_wr == LEN && seq_err == 0, "R10 start ignored mid-run", run_wr, LEN);
        check(done && !fail, "R10 run completes normally", int'(fail), 0);
    endtask

    task automatic t_restart;
        run(1, 1'b1, 1'b0);
        check(fail == 1'b1, "R9 failing run before restart", int'(fail), 1);
        run(0, 1'b0, 1'b0);
        check(done && !fail, "R9 restart clears old failure", int'(fail), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good();
        t_alias(1'b0);
        t_alias(1'b1);
        t_stuck(1'b0);
        t_stuck(1'b1);
        t_busy_start();
        t_restart();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule